// File: doc/BRIEF.md
# Phase-Based Clock and Receiver Power Gate

This block lets a front-end chip draw digital power only while it has work to do. It holds the enable of the clock-input receiver and a glitch-free gate on the digital clock. Two independent sources can request power. A level request from the acquisition system covers acquisition and conversion. A token from the previous chip in a readout chain covers this chip's readout. Power-on is asynchronous, so a request needs no running clock to take effect. Power-off is synchronous and is delayed through a short register chain, so the clock always stops on a whole pulse and the receiver is released only after the clock has gone quiet.

When a readout token arrives, the receiver comes up at once. The gated clock resumes a fixed number of raw clock edges later. A one-cycle internal start-readout pulse is then presented so that the readout state machines see it on their first gated clock edge. The local readout logic ends the phase with an end-readout level, which is sampled on the raw clock. The gated clock idles low. The block has no data stream, so all pins are plain control levels.

Top module: `pwr_phase_gate`

## Requirements
- R1: While rst_n is low and pwr_req is low, rx_en, clk_gated and ro_start_int are all 0.
- R2: pwr_req high drives rx_en high at once, with no clock edge needed, and this holds even while rst_n is low.
- R3: While power is on, clk_gated copies every raw clock pulse whole. When the gate is closed, clk_gated stays at 0, and it is always 0 while clk_raw is low.
- R4: After pwr_req is sampled low, clk_gated still passes the pulses that start at the next SYNC_DEPTH (default 2) raw rising edges and none after. rx_en from this source falls at raw rising edge SYNC_DEPTH+1.
- R5: A high level on ro_start drives rx_en high at once, unless rst_n is low.
- R6: After a token, the first gated pulse begins at raw rising edge SYNC_DEPTH+1 that follows it. ro_start_int is high for exactly the one raw cycle that ends at that edge.
- R7: ro_end sampled high at raw rising edge E, with ro_start low, ends readout. Gated pulses continue at edges E through E+SYNC_DEPTH, and rx_en from readout falls at edge E+SYNC_DEPTH+1.
- R8: ro_start high overrides ro_end. ro_end while no readout is pending has no effect on any output.
- R9: The two sources are ORed. Releasing either one while the other is active leaves clk_gated and rx_en running.
- R10: rst_n low ends readout power at once (rx_en falls with no clock edge when pwr_req is low), but it does not remove power requested by pwr_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_raw | input | 1 | Free-running clock from the receiver output |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_req | input | 1 | Power request level for acquisition and conversion |
| ro_start | input | 1 | Readout token from the previous chip, asynchronous |
| ro_end | input | 1 | End-of-readout level from the local readout logic |
| clk_gated | output | 1 | Gated digital clock, idle low |
| rx_en | output | 1 | Clock receiver enable |
| ro_start_int | output | 1 | One-cycle internal start-readout pulse |

## Verification
The assertions assume that reset is held well beyond the receiver wake-up time once pwr_req is raised, and that pwr_req does not fall while rst_n is low. They also assume that ro_start and ro_end change away from the raw clock's rising edge, and they are disabled while reset is active. The stimulus drives every input on the falling edge of the raw clock, holds reset for 25 cycles after power is requested, and releases pwr_req only after reset is released. It covers the single-source sequences, overlapping sources, simultaneous token and end-readout, a stray end-readout, and a reset that lands mid-readout.

// File: rtl/pwr_phase_gate_pkg.sv
package pwr_phase_gate_pkg;
  // one power vote: receiver enable and clock enable
  typedef struct packed {
    logic rx_on;
    logic clk_on;
  } pwr_vote_t;

  localparam int unsigned PG_DEPTH_DEFAULT = 2;

  function automatic pwr_vote_t vote_or(input pwr_vote_t a, input pwr_vote_t b);
    pwr_vote_t r;
    r.rx_on  = a.rx_on | b.rx_on;
    r.clk_on = a.clk_on | b.clk_on;
    return r;
  endfunction
endpackage

// File: rtl/pg_acq_hold.sv
module pg_acq_hold
  import pwr_phase_gate_pkg::*;
#(
  parameter int unsigned DEPTH = PG_DEPTH_DEFAULT
) (
  input  logic      clk_raw,
  input  logic      rst_n,
  input  logic      pwr_req,
  output pwr_vote_t vote
);
  localparam int unsigned LEN = DEPTH + 1;

  // all stages set asynchronously by the request, drained by zeros on release
  logic [LEN-1:0] hold_q;

  always_ff @(posedge clk_raw or posedge pwr_req or negedge rst_n) begin
    if (pwr_req)     hold_q <= '1;
    else if (!rst_n) hold_q <= '0;
    else             hold_q <= {hold_q[LEN-2:0], 1'b0};
  end

  assign vote.clk_on = hold_q[DEPTH-1];
  assign vote.rx_on  = hold_q[DEPTH];

  a_r2_rx_with_req: assert property (@(posedge clk_raw) disable iff (!rst_n)
    pwr_req |-> vote.rx_on);
  a_r4_clk_needs_rx: assert property (@(posedge clk_raw) disable iff (!rst_n)
    vote.clk_on |-> vote.rx_on);
  a_r4_clk_stops_first: assert property (@(posedge clk_raw) disable iff (!rst_n)
    $fell(vote.rx_on) |-> !$past(vote.clk_on));
endmodule

// File: rtl/pg_ro_token.sv
module pg_ro_token
  import pwr_phase_gate_pkg::*;
#(
  parameter int unsigned DEPTH = PG_DEPTH_DEFAULT
) (
  input  logic      clk_raw,
  input  logic      rst_n,
  input  logic      ro_start,
  input  logic      ro_end,
  output pwr_vote_t vote,
  output logic      start_pulse
);
  localparam int unsigned LEN = DEPTH + 1;

  logic           tok_q;
  logic [LEN-1:0] trail_q;

  // token flag: set without a clock, cleared by end-readout on the raw clock
  always_ff @(posedge clk_raw or posedge ro_start or negedge rst_n) begin
    if (!rst_n)        tok_q <= 1'b0;
    else if (ro_start) tok_q <= 1'b1;
    else if (ro_end)   tok_q <= 1'b0;
  end

  // synchroniser followed by one extra stage that delays the receiver release
  always_ff @(posedge clk_raw or negedge rst_n) begin
    if (!rst_n) trail_q <= '0;
    else        trail_q <= {trail_q[LEN-2:0], tok_q};
  end

  assign vote.clk_on = trail_q[DEPTH-1];
  assign vote.rx_on  = tok_q | (|trail_q);
  assign start_pulse = trail_q[DEPTH-1] & ~trail_q[DEPTH];

  a_r6_start_single: assert property (@(posedge clk_raw) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r7_clk_needs_rx: assert property (@(posedge clk_raw) disable iff (!rst_n)
    vote.clk_on |-> vote.rx_on);
  a_r8_start_wins: assert property (@(posedge clk_raw) disable iff (!rst_n)
    ro_start |-> tok_q);
endmodule

// File: rtl/pg_clk_gate.sv
module pg_clk_gate (
  input  logic clk_raw,
  input  logic en,
  output logic clk_out
);
  logic en_l;

  // latch opens only while the raw clock is low, so a pulse is never cut
  always_latch begin
    if (!clk_raw) en_l = en;
  end

  assign clk_out = clk_raw & en_l;
endmodule

// File: rtl/pwr_phase_gate.sv
module pwr_phase_gate
  import pwr_phase_gate_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = PG_DEPTH_DEFAULT
) (
  input  logic clk_raw,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic ro_start,
  input  logic ro_end,
  output logic clk_gated,
  output logic rx_en,
  output logic ro_start_int
);
  pwr_vote_t acq_vote, ro_vote, all_vote;

  pg_acq_hold #(.DEPTH(SYNC_DEPTH)) u_acq (
    .clk_raw (clk_raw),
    .rst_n   (rst_n),
    .pwr_req (pwr_req),
    .vote    (acq_vote)
  );

  pg_ro_token #(.DEPTH(SYNC_DEPTH)) u_ro (
    .clk_raw     (clk_raw),
    .rst_n       (rst_n),
    .ro_start    (ro_start),
    .ro_end      (ro_end),
    .vote        (ro_vote),
    .start_pulse (ro_start_int)
  );

  assign all_vote = vote_or(acq_vote, ro_vote);
  assign rx_en    = all_vote.rx_on;

  pg_clk_gate u_gate (
    .clk_raw (clk_raw),
    .en      (all_vote.clk_on),
    .clk_out (clk_gated)
  );

  a_r9_either_source: assert property (@(posedge clk_raw) disable iff (!rst_n)
    (acq_vote.rx_on || ro_vote.rx_on) |-> rx_en);
  a_r3_no_clock_without_rx: assert property (@(negedge clk_raw) disable iff (!rst_n)
    all_vote.clk_on |-> rx_en);
endmodule

// File: tb/test_pwr_phase_gate.sv
module test_pwr_phase_gate;
  localparam int DEPTH = 2;
  localparam int BIG   = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0, pwr_req = 1'b0, ro_start = 1'b0, ro_end = 1'b0;
  logic clk_gated, rx_en, ro_start_int;

  pwr_phase_gate #(.SYNC_DEPTH(DEPTH)) i_pwr_phase_gate (
    .clk_raw(clk), .rst_n(rst_n), .pwr_req(pwr_req), .ro_start(ro_start),
    .ro_end(ro_end), .clk_gated(clk_gated), .rx_en(rx_en), .ro_start_int(ro_start_int)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  int    acq_cnt = BIG;        // raw edges seen with the request low
  bit    ro_act = 1'b0;        // readout pending
  bit    hist [0:DEPTH];       // readout-pending samples, newest first
  int    n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  initial for (int i = 0; i <= DEPTH; i++) hist[i] = 1'b0;

  function automatic bit m_clk_en();
    return (acq_cnt < DEPTH) || hist[DEPTH-1];
  endfunction
  function automatic bit m_rx();
    bit any = 1'b0;
    for (int i = 0; i <= DEPTH; i++) any |= hist[i];
    return (acq_cnt < DEPTH + 1) || ro_act || any;
  endfunction
  function automatic bit m_start();
    return hist[DEPTH-1] && !hist[DEPTH];
  endfunction

  task automatic chk(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", cur_req, what, $time, act, exp);
    end
  endtask

  // rising-edge model update and compare
  always @(posedge clk) begin
    bit g;
    if (!done) begin
      g = m_clk_en();
      if (pwr_req) acq_cnt = 0;
      else if (!rst_n) acq_cnt = BIG;
      else if (acq_cnt < BIG) acq_cnt++;
      if (!rst_n) begin
        for (int i = 0; i <= DEPTH; i++) hist[i] = 1'b0;
        ro_act = 1'b0;
      end else begin
        for (int i = DEPTH; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = ro_act;
        if (ro_start) ro_act = 1'b1;
        else if (ro_end) ro_act = 1'b0;
      end
      #2;
      chk("clk_gated high phase", clk_gated, g);
      chk("rx_en", rx_en, m_rx());
      chk("ro_start_int", ro_start_int, m_start());
    end
  end

  // low-phase compare, after asynchronous input changes
  always @(negedge clk) begin
    if (!done) begin
      #1;
      chk("clk_gated idle low", clk_gated, 1'b0);
      chk("rx_en async", rx_en, m_rx());
      chk("ro_start_int low phase", ro_start_int, m_start());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_pwr(input logic v);
    pwr_req = v;
    if (v) acq_cnt = 0;
  endtask
  task automatic set_tok(input logic v);
    ro_start = v;
    if (v && rst_n) ro_act = 1'b1;
  endtask
  task automatic set_rst(input logic v);
    rst_n = v;
    if (!v) begin
      if (!pwr_req) acq_cnt = BIG;
      ro_act = 1'b0;
      for (int i = 0; i <= DEPTH; i++) hist[i] = 1'b0;
    end
  endtask
  task automatic pulse_tok(); set_tok(1'b1); tick(1); set_tok(1'b0); endtask
  task automatic pulse_end(); ro_end = 1'b1; tick(1); ro_end = 1'b0; endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cur_req = "R1"; tick(4);
    cur_req = "R2"; set_pwr(1'b1); tick(25);
    set_rst(1'b1);
    cur_req = "R3"; tick(8);
    cur_req = "R4"; set_pwr(1'b0); tick(6);
    cur_req = "R5"; pulse_tok();
    cur_req = "R6"; tick(8);
    cur_req = "R7"; pulse_end(); tick(6);
    cur_req = "R8"; pulse_end(); tick(4);
    set_tok(1'b1); ro_end = 1'b1; tick(2); set_tok(1'b0); ro_end = 1'b0; tick(5);
    pulse_end(); tick(5);
    cur_req = "R9"; set_pwr(1'b1); tick(3); pulse_tok(); tick(5);
    set_pwr(1'b0); tick(5); pulse_end(); tick(6);
    set_pwr(1'b1); tick(2); pulse_tok(); tick(4); pulse_end(); tick(5);
    set_pwr(1'b0); tick(5);
    cur_req = "R10"; pulse_tok(); tick(5); set_rst(1'b0); tick(3);
    set_pwr(1'b1); tick(3); pulse_tok(); tick(2); set_rst(1'b1); tick(4);
    set_rst(1'b0); tick(3); set_rst(1'b1); tick(2); set_pwr(1'b0); tick(5);
    cur_req = "R6"; set_tok(1'b1); tick(4); set_tok(1'b0); tick(4);
    cur_req = "R7"; pulse_end(); tick(6);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule